// File: doc/BRIEF.md
# SD Host Control Register Bank

This block is the software-visible register file of an SD/MMC host controller. A Wishbone-style slave port gives access to a set of 32-bit words. These words set up a card command: its argument, index, response kind, checks and data phase. They also hold the link settings: bus width, timeout, clock divider and software reset. The data-transfer geometry is held too: block size, block count and the DMA address. Every configuration field drives the protocol engine and the DMA, which sit outside this block, through plain output ports.

Writing the argument word launches a command. The bank emits a one-cycle start pulse while the command fields hold the values last written. The protocol engine reports what happened through per-event set inputs. The bank keeps each event in a sticky status word for the command group and another for the data group. Any write to a status word wipes the whole word. Each group has an enable word, and the group's interrupt is raised when any status bit and its enable bit are both 1. The response words are read straight from a core-side port. The voltage word returns a build-time constant, and the capabilities word reads as zero.

Top module: `sd_host_regs`

## Requirements
- R1: A bus access (cyc and stb high, ack low) is answered with ack high in the following cycle, for exactly one cycle. Read data is valid while ack is high and holds the word's contents from before any write in that same access.
- R2: After reset, block size and block count read 0x200 and every other writable word reads 0.
- R3: Word index = address bits [7:2]. The writable words and the bits they keep are: argument 0x00 [31:0], command 0x04 [13:8] and [6:0], control 0x1C [0], timeout 0x20 [15:0], divider 0x24 [7:0], software reset 0x28 [0], command enable 0x38 [4:0], data enable 0x40 [2:0], block size 0x44 [11:0], block count 0x48 [11:0], DMA address 0x60 [31:0]. Any other bit written is dropped and reads as 0.
- R4: The command word drives the core-side fields as follows: index from bits [13:8], data phase from [6:5] (0 none, 1 read, 2 write), index check from bit 4, CRC check from bit 3, busy wait from bit 2, and response kind from [1:0] (0 none, 1 short, 2 long). Control bit 0 drives the 4-bit bus select.
- R5: A write to the argument word raises the start output for exactly one cycle, in the cycle that its ack is high. Writes to any other word and all reads leave start low.
- R6: Response words at 0x08, 0x0C, 0x10 and 0x14 read bits [31:0], [63:32], [95:64] and [127:96] of the response input. Voltage at 0x2C reads the millivolt parameter, and capabilities at 0x30 reads 0. Writes to these words have no effect.
- R7: The command status word (0x34) latches its set inputs as sticky bits: bit 0 done, bit 2 timeout, bit 3 CRC, bit 4 index. Bit 1 is set whenever bit 1, 2, 3 or 4 is set. The data status word (0x3C) latches bit 0 done, bit 1 CRC and bit 2 FIFO.
- R8: A write of any value to a status word clears all of its bits. A read of a status word leaves it unchanged.
- R9: An event set in the same cycle as a clearing write stays set.
- R10: Each group's interrupt output is high exactly when some status bit and its enable bit are both 1.
- R11: Addresses with no word assigned read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| wbCyc | input | 1 | bus cycle |
| wbStb | input | 1 | bus strobe |
| wbWe | input | 1 | write enable |
| wbAdr | input | 8 | byte address |
| wbDatI | input | 32 | write data |
| wbDatO | output | 32 | read data |
| wbAck | output | 1 | access acknowledge |
| respData | input | 128 | response bits from the protocol engine |
| cmdEvtSet | input | 5 | command event set pulses |
| dataEvtSet | input | 3 | data event set pulses |
| cmdStart | output | 1 | command launch pulse |
| cmdArg | output | 32 | command argument |
| cmdIndex | output | 6 | command index |
| dataMode | output | 2 | data phase select |
| idxCheck | output | 1 | response index check enable |
| crcCheck | output | 1 | response CRC check enable |
| busyWait | output | 1 | wait for busy after command |
| respMode | output | 2 | response kind |
| busWide | output | 1 | 4-bit bus select |
| timeoutVal | output | 16 | transaction timeout |
| clkDiv | output | 8 | card clock divider |
| swReset | output | 1 | software reset |
| blkSize | output | 12 | bytes per block |
| blkCount | output | 12 | blocks per transfer |
| dmaAddr | output | 32 | DMA address |
| cmdIrq | output | 1 | command group interrupt |
| dataIrq | output | 1 | data group interrupt |

## Verification
Random writes of random 32-bit values go to random writable words. Each is read back, which separates correct bit retention from wrong address decode and missing reserved-bit masks. The same writes also show whether start fires only for the argument word. Directed sequences work through the status words: a single error event, which shows whether the summary bit is raised; a read, which must not clear; a clearing write; and a clearing write that lands on a set pulse, which exposes a clear-over-set priority error. Enable toggling separates masked events from the ones that reach the interrupt. Writes to the response word and to an unassigned address show whether read-only and unmapped words are really left alone.

// File: rtl/sd_host_regs_pkg.sv
package sd_host_regs_pkg;
  localparam int ADDR_W    = 8;
  localparam int IDX_W     = ADDR_W - 2;
  localparam int TMO_W     = 16;
  localparam int DIV_W     = 8;
  localparam int BLK_W     = 12;
  localparam int CMD_EVT_W = 5;
  localparam int DAT_EVT_W = 3;

  // word indices (byte address / 4)
  localparam logic [IDX_W-1:0] IX_ARG  = 6'd0;
  localparam logic [IDX_W-1:0] IX_CMD  = 6'd1;
  localparam logic [IDX_W-1:0] IX_RSP0 = 6'd2;
  localparam logic [IDX_W-1:0] IX_RSP1 = 6'd3;
  localparam logic [IDX_W-1:0] IX_RSP2 = 6'd4;
  localparam logic [IDX_W-1:0] IX_RSP3 = 6'd5;
  localparam logic [IDX_W-1:0] IX_CTRL = 6'd7;
  localparam logic [IDX_W-1:0] IX_TMO  = 6'd8;
  localparam logic [IDX_W-1:0] IX_DIV  = 6'd9;
  localparam logic [IDX_W-1:0] IX_RST  = 6'd10;
  localparam logic [IDX_W-1:0] IX_VOLT = 6'd11;
  localparam logic [IDX_W-1:0] IX_CAPS = 6'd12;
  localparam logic [IDX_W-1:0] IX_CSTA = 6'd13;
  localparam logic [IDX_W-1:0] IX_CEN  = 6'd14;
  localparam logic [IDX_W-1:0] IX_DSTA = 6'd15;
  localparam logic [IDX_W-1:0] IX_DEN  = 6'd16;
  localparam logic [IDX_W-1:0] IX_BSZ  = 6'd17;
  localparam logic [IDX_W-1:0] IX_BCNT = 6'd18;
  localparam logic [IDX_W-1:0] IX_DMA  = 6'd24;

  typedef struct packed {
    logic argWr;
    logic cmdWr;
    logic ctrlWr;
    logic tmoWr;
    logic divWr;
    logic rstWr;
    logic cStaWr;
    logic cEnWr;
    logic dStaWr;
    logic dEnWr;
    logic bszWr;
    logic bcntWr;
    logic dmaWr;
    logic rdEn;
    logic [IDX_W-1:0] rdIdx;
  } regStrobe_t;
endpackage

// File: rtl/sd_regs_ctrl.sv
module sd_regs_ctrl
  import sd_host_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wbCyc,
  input  logic              wbStb,
  input  logic              wbWe,
  input  logic [ADDR_W-1:0] wbAdr,
  output logic              wbAck,
  output logic              startPulse,
  output regStrobe_t        strobe
);
  logic access;
  logic wrAcc;
  logic [IDX_W-1:0] idx;

  assign access = wbCyc & wbStb & ~wbAck;
  assign wrAcc  = access & wbWe;
  assign idx    = wbAdr[ADDR_W-1:2];

  always_comb begin
    strobe        = '0;
    strobe.rdEn   = access;
    strobe.rdIdx  = idx;
    strobe.argWr  = wrAcc & (idx == IX_ARG);
    strobe.cmdWr  = wrAcc & (idx == IX_CMD);
    strobe.ctrlWr = wrAcc & (idx == IX_CTRL);
    strobe.tmoWr  = wrAcc & (idx == IX_TMO);
    strobe.divWr  = wrAcc & (idx == IX_DIV);
    strobe.rstWr  = wrAcc & (idx == IX_RST);
    strobe.cStaWr = wrAcc & (idx == IX_CSTA);
    strobe.cEnWr  = wrAcc & (idx == IX_CEN);
    strobe.dStaWr = wrAcc & (idx == IX_DSTA);
    strobe.dEnWr  = wrAcc & (idx == IX_DEN);
    strobe.bszWr  = wrAcc & (idx == IX_BSZ);
    strobe.bcntWr = wrAcc & (idx == IX_BCNT);
    strobe.dmaWr  = wrAcc & (idx == IX_DMA);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wbAck      <= 1'b0;
      startPulse <= 1'b0;
    end else begin
      wbAck      <= access;
      startPulse <= strobe.argWr;
    end
  end
endmodule

// File: rtl/sd_regs_dp.sv
module sd_regs_dp
  import sd_host_regs_pkg::*;
#(
  parameter int unsigned VOLTAGE_MV = 3300,
  parameter int unsigned BLK_RST    = 512
) (
  input  logic                 clk,
  input  logic                 rst,
  input  regStrobe_t           strobe,
  input  logic [31:0]          wrData,
  input  logic [127:0]         respData,
  input  logic [CMD_EVT_W-1:0] cmdEvtSet,
  input  logic [DAT_EVT_W-1:0] dataEvtSet,
  output logic [31:0]          rdData,
  output logic [31:0]          argQ,
  output logic [13:0]          cmdQ,
  output logic                 ctrlQ,
  output logic [TMO_W-1:0]     tmoQ,
  output logic [DIV_W-1:0]     divQ,
  output logic                 rstQ,
  output logic [BLK_W-1:0]     bszQ,
  output logic [BLK_W-1:0]     bcntQ,
  output logic [31:0]          dmaQ,
  output logic [CMD_EVT_W-1:0] cmdStat,
  output logic [CMD_EVT_W-1:0] cmdEn,
  output logic [DAT_EVT_W-1:0] datStat,
  output logic [DAT_EVT_W-1:0] datEn,
  output logic                 cmdIrq,
  output logic                 dataIrq
);
  localparam logic [13:0]      CMD_KEEP = 14'h3F7F;
  localparam logic [BLK_W-1:0] BLK_INIT = BLK_W'(BLK_RST);

  logic [CMD_EVT_W-1:0] cmdSetEff;
  logic [31:0]          rdMux;

  // summary error bit follows any error source
  assign cmdSetEff = {cmdEvtSet[CMD_EVT_W-1:2],
                      cmdEvtSet[1] | (|cmdEvtSet[CMD_EVT_W-1:2]),
                      cmdEvtSet[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      argQ  <= '0;
      cmdQ  <= '0;
      ctrlQ <= 1'b0;
      tmoQ  <= '0;
      divQ  <= '0;
      rstQ  <= 1'b0;
      bszQ  <= BLK_INIT;
      bcntQ <= BLK_INIT;
      dmaQ  <= '0;
      cmdEn <= '0;
      datEn <= '0;
    end else begin
      if (strobe.argWr)  argQ  <= wrData;
      if (strobe.cmdWr)  cmdQ  <= wrData[13:0] & CMD_KEEP;
      if (strobe.ctrlWr) ctrlQ <= wrData[0];
      if (strobe.tmoWr)  tmoQ  <= wrData[TMO_W-1:0];
      if (strobe.divWr)  divQ  <= wrData[DIV_W-1:0];
      if (strobe.rstWr)  rstQ  <= wrData[0];
      if (strobe.bszWr)  bszQ  <= wrData[BLK_W-1:0];
      if (strobe.bcntWr) bcntQ <= wrData[BLK_W-1:0];
      if (strobe.dmaWr)  dmaQ  <= wrData;
      if (strobe.cEnWr)  cmdEn <= wrData[CMD_EVT_W-1:0];
      if (strobe.dEnWr)  datEn <= wrData[DAT_EVT_W-1:0];
    end
  end

  // sticky status: clear first, then OR in new events (set wins)
  always_ff @(posedge clk) begin
    if (rst) begin
      cmdStat <= '0;
      datStat <= '0;
    end else begin
      cmdStat <= (strobe.cStaWr ? '0 : cmdStat) | cmdSetEff;
      datStat <= (strobe.dStaWr ? '0 : datStat) | dataEvtSet;
    end
  end

  always_comb begin
    unique case (strobe.rdIdx)
      IX_ARG:  rdMux = argQ;
      IX_CMD:  rdMux = 32'(cmdQ);
      IX_RSP0: rdMux = respData[31:0];
      IX_RSP1: rdMux = respData[63:32];
      IX_RSP2: rdMux = respData[95:64];
      IX_RSP3: rdMux = respData[127:96];
      IX_CTRL: rdMux = 32'(ctrlQ);
      IX_TMO:  rdMux = 32'(tmoQ);
      IX_DIV:  rdMux = 32'(divQ);
      IX_RST:  rdMux = 32'(rstQ);
      IX_VOLT: rdMux = 32'(VOLTAGE_MV);
      IX_CSTA: rdMux = 32'(cmdStat);
      IX_CEN:  rdMux = 32'(cmdEn);
      IX_DSTA: rdMux = 32'(datStat);
      IX_DEN:  rdMux = 32'(datEn);
      IX_BSZ:  rdMux = 32'(bszQ);
      IX_BCNT: rdMux = 32'(bcntQ);
      IX_DMA:  rdMux = dmaQ;
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)              rdData <= '0;
    else if (strobe.rdEn) rdData <= rdMux;
  end

  assign cmdIrq  = |(cmdStat & cmdEn);
  assign dataIrq = |(datStat & datEn);
endmodule

// File: rtl/sd_host_regs.sv
module sd_host_regs
  import sd_host_regs_pkg::*;
#(
  parameter int unsigned VOLTAGE_MV = 3300,
  parameter int unsigned BLK_RST    = 512
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wbCyc,
  input  logic                 wbStb,
  input  logic                 wbWe,
  input  logic [ADDR_W-1:0]    wbAdr,
  input  logic [31:0]          wbDatI,
  output logic [31:0]          wbDatO,
  output logic                 wbAck,
  input  logic [127:0]         respData,
  input  logic [CMD_EVT_W-1:0] cmdEvtSet,
  input  logic [DAT_EVT_W-1:0] dataEvtSet,
  output logic                 cmdStart,
  output logic [31:0]          cmdArg,
  output logic [5:0]           cmdIndex,
  output logic [1:0]           dataMode,
  output logic                 idxCheck,
  output logic                 crcCheck,
  output logic                 busyWait,
  output logic [1:0]           respMode,
  output logic                 busWide,
  output logic [TMO_W-1:0]     timeoutVal,
  output logic [DIV_W-1:0]     clkDiv,
  output logic                 swReset,
  output logic [BLK_W-1:0]     blkSize,
  output logic [BLK_W-1:0]     blkCount,
  output logic [31:0]          dmaAddr,
  output logic                 cmdIrq,
  output logic                 dataIrq
);
  regStrobe_t           strobe;
  logic [13:0]          cmdQ;
  logic [CMD_EVT_W-1:0] cmdStat, cmdEn;
  logic [DAT_EVT_W-1:0] datStat, datEn;

  sd_regs_ctrl uCtrl (
    .clk(clk), .rst(rst), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
    .wbAdr(wbAdr), .wbAck(wbAck), .startPulse(cmdStart), .strobe(strobe)
  );

  sd_regs_dp #(.VOLTAGE_MV(VOLTAGE_MV), .BLK_RST(BLK_RST)) uDp (
    .clk(clk), .rst(rst), .strobe(strobe), .wrData(wbDatI),
    .respData(respData), .cmdEvtSet(cmdEvtSet), .dataEvtSet(dataEvtSet),
    .rdData(wbDatO), .argQ(cmdArg), .cmdQ(cmdQ), .ctrlQ(busWide),
    .tmoQ(timeoutVal), .divQ(clkDiv), .rstQ(swReset), .bszQ(blkSize),
    .bcntQ(blkCount), .dmaQ(dmaAddr), .cmdStat(cmdStat), .cmdEn(cmdEn),
    .datStat(datStat), .datEn(datEn), .cmdIrq(cmdIrq), .dataIrq(dataIrq)
  );

  assign cmdIndex = cmdQ[13:8];
  assign dataMode = cmdQ[6:5];
  assign idxCheck = cmdQ[4];
  assign crcCheck = cmdQ[3];
  assign busyWait = cmdQ[2];
  assign respMode = cmdQ[1:0];
endmodule

// File: rtl/sd_host_regs_chk.sv
module sd_host_regs_chk
  import sd_host_regs_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 wbCyc,
  input logic                 wbStb,
  input logic                 wbWe,
  input logic [ADDR_W-1:0]    wbAdr,
  input logic                 wbAck,
  input logic                 cmdStart,
  input logic [CMD_EVT_W-1:0] cmdEvtSet,
  input logic [CMD_EVT_W-1:0] cmdStat
);
  logic cStaClr;
  assign cStaClr = wbCyc & wbStb & wbWe & ~wbAck & (wbAdr[ADDR_W-1:2] == IX_CSTA);

  a_r1_ack_follows: assert property (@(posedge clk) disable iff (rst)
    (wbCyc && wbStb && !wbAck) |=> wbAck);

  a_r1_ack_single: assert property (@(posedge clk) disable iff (rst)
    wbAck |=> !wbAck);

  a_r5_start_with_ack: assert property (@(posedge clk) disable iff (rst)
    cmdStart |-> wbAck);

  a_r5_start_from_arg: assert property (@(posedge clk) disable iff (rst)
    (wbCyc && wbStb && !wbAck && !(wbWe && wbAdr[ADDR_W-1:2] == IX_ARG)) |=> !cmdStart);

  a_r9_set_sticks: assert property (@(posedge clk) disable iff (rst)
    (cmdEvtSet != '0) |=> ((cmdStat & $past(cmdEvtSet)) == $past(cmdEvtSet)));

  a_r7_status_holds: assert property (@(posedge clk) disable iff (rst)
    (cmdEvtSet == '0 && !cStaClr) |=> (cmdStat == $past(cmdStat)));
endmodule

bind sd_host_regs sd_host_regs_chk uChk (
  .clk(clk), .rst(rst), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
  .wbAdr(wbAdr), .wbAck(wbAck), .cmdStart(cmdStart),
  .cmdEvtSet(cmdEvtSet), .cmdStat(cmdStat)
);

// File: tb/sd_host_regs_test.sv
module sd_host_regs_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wbCyc = 0, wbStb = 0, wbWe = 0;
  logic [7:0] wbAdr = '0;
  logic [31:0] wbDatI = '0;
  logic [31:0] wbDatO;
  logic wbAck;
  logic [127:0] respData = 128'h0123_4567_89AB_CDEF_F0E1_D2C3_B4A5_9687;
  logic [4:0] cmdEvtSet = '0;
  logic [2:0] dataEvtSet = '0;
  logic cmdStart;
  logic [31:0] cmdArg, dmaAddr;
  logic [5:0] cmdIndex;
  logic [1:0] dataMode, respMode;
  logic idxCheck, crcCheck, busyWait, busWide, swReset, cmdIrq, dataIrq;
  logic [15:0] timeoutVal;
  logic [7:0] clkDiv;
  logic [11:0] blkSize, blkCount;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  logic [31:0] model [0:31];

  always #5 clk = ~clk;

  sd_host_regs uut (.*);

  function automatic logic [31:0] rwMask(int idx);
    case (idx)
      0, 24:   return 32'hFFFF_FFFF;
      1:       return 32'h0000_3F7F;
      7, 10:   return 32'h1;
      8:       return 32'hFFFF;
      9:       return 32'hFF;
      14:      return 32'h1F;
      16:      return 32'h7;
      17, 18:  return 32'hFFF;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit we, input logic [7:0] adr, input logic [31:0] dat,
                      input logic [4:0] setSame, output logic [31:0] rd,
                      output logic ack, output logic start);
    @(negedge clk);
    wbCyc = 1; wbStb = 1; wbWe = we; wbAdr = adr; wbDatI = dat;
    cmdEvtSet = setSame;
    @(negedge clk);
    rd = wbDatO; ack = wbAck; start = cmdStart;
    wbCyc = 0; wbStb = 0; wbWe = 0; cmdEvtSet = '0;
  endtask

  task automatic rdWord(input logic [7:0] adr, output logic [31:0] rd);
    logic a, s;
    xfer(0, adr, 0, 5'd0, rd, a, s);
  endtask

  task automatic wrWord(input logic [7:0] adr, input logic [31:0] dat);
    logic [31:0] d;
    logic a, s;
    xfer(1, adr, dat, 5'd0, d, a, s);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic ack, st;
    void'($urandom(32'h5D0C));
    for (int i = 0; i < 32; i++) model[i] = 32'h0;
    model[17] = 32'h200;
    model[18] = 32'h200;
    repeat (3) @(negedge clk);
    rst = 0;

    // R2 reset values, R6 read-only words
    for (int i = 0; i < 25; i++) begin
      rdWord(8'(i * 4), rd);
      if (rwMask(i) != 0) check("R2 reset value", rd, model[i]);
    end
    rdWord(8'h2C, rd); check("R6 voltage", rd, 32'd3300);
    rdWord(8'h30, rd); check("R6 capabilities", rd, 32'h0);
    rdWord(8'h08, rd); check("R6 resp0", rd, respData[31:0]);
    rdWord(8'h14, rd); check("R6 resp3", rd, respData[127:96]);

    // R1 ack timing
    xfer(0, 8'h00, 0, 5'd0, rd, ack, st);
    check("R1 ack high", 32'(ack), 32'd1);
    @(negedge clk);
    check("R1 ack single cycle", 32'(wbAck), 32'd0);

    // R3 R4 R5 random writes with readback
    for (int n = 0; n < 80; n++) begin
      int list [11] = '{0, 1, 7, 8, 9, 10, 14, 16, 17, 18, 24};
      int idx = list[$urandom % 11];
      logic [31:0] dat = $urandom;
      xfer(1, 8'(idx * 4), dat, 5'd0, rd, ack, st);
      check("R5 start only on argument write", 32'(st), 32'(idx == 0));
      model[idx] = dat & rwMask(idx);
      rdWord(8'(idx * 4), rd);
      check("R3 readback", rd, model[idx]);
      if (idx == 1) begin
        check("R4 fields", {cmdIndex, dataMode, idxCheck, crcCheck, busyWait, respMode},
              {dat[13:8], dat[6:5], dat[4], dat[3], dat[2], dat[1:0]});
      end
      if (idx == 7) check("R4 bus width", 32'(busWide), 32'(dat[0]));
    end
    check("R5 argument output", cmdArg, model[0]);

    // R6 R11 writes to read-only and unmapped words
    wrWord(8'h08, 32'hDEAD_BEEF);
    rdWord(8'h08, rd); check("R6 resp write ignored", rd, respData[31:0]);
    wrWord(8'h18, 32'hFFFF_FFFF);
    rdWord(8'h18, rd); check("R11 unmapped reads zero", rd, 32'h0);
    wrWord(8'h30, 32'hFFFF_FFFF);
    rdWord(8'h30, rd); check("R11 capabilities write ignored", rd, 32'h0);

    // R7 R8 R10 command group
    wrWord(8'h38, 32'h0);
    wrWord(8'h34, 32'h0);
    @(negedge clk); cmdEvtSet = 5'b00100;
    @(negedge clk); cmdEvtSet = '0;
    rdWord(8'h34, rd); check("R7 timeout sets summary", rd, 32'h06);
    check("R10 masked event no irq", 32'(cmdIrq), 32'd0);
    wrWord(8'h38, 32'h04);
    check("R10 enabled event irq", 32'(cmdIrq), 32'd1);
    rdWord(8'h34, rd); check("R8 read does not clear", rd, 32'h06);
    wrWord(8'h34, 32'h0000_0000);
    rdWord(8'h34, rd); check("R8 write clears", rd, 32'h0);
    check("R10 irq drops after clear", 32'(cmdIrq), 32'd0);

    // R9 set wins over clear
    @(negedge clk); cmdEvtSet = 5'b01000;
    @(negedge clk); cmdEvtSet = '0;
    xfer(1, 8'h34, 32'h1F, 5'b00001, rd, ack, st);
    rdWord(8'h34, rd); check("R9 set wins over clear", rd, 32'h01);

    // R7 R8 R10 data group
    wrWord(8'h40, 32'h0);
    @(negedge clk); dataEvtSet = 3'b101;
    @(negedge clk); dataEvtSet = '0;
    rdWord(8'h3C, rd); check("R7 data status", rd, 32'h5);
    check("R10 data masked", 32'(dataIrq), 32'd0);
    wrWord(8'h40, 32'h4);
    check("R10 data irq", 32'(dataIrq), 32'd1);
    wrWord(8'h3C, 32'hABCD);
    rdWord(8'h3C, rd); check("R8 data clear", rd, 32'h0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule